// File: doc/BRIEF.md
# Timer Counter with Compare and Capture

This block is a general-purpose event timer. A counter of configurable width steps once per clock in which the count-enable input is high and the timer is running. It counts up, counts down, or climbs to the period value and then falls back to zero. It can run continuously or stop after a single period. Each wrap or reversal raises an overflow or underflow event.

A compare value is checked against every new count. When swapping is enabled, each compare match exchanges the active compare value with a second, buffered one. A capture strobe stores the present count and shifts the older capture into a backup register. Four events (overflow, underflow, capture, compare) set sticky flags and can drive a one-cycle trigger output.

Software loads the period, both compare values and the mode word through a write-only register port. All control and status pins are plain single-cycle levels. The block has no streaming data path, so no valid/ready handshake applies. Start, stop, reload, capture and count-enable are expected to be already synchronized to `clk`.

Top module: `evt_timer`

## Requirements
- R1: In up mode (mode field bits [1:0] = 0), each count step adds one. A step taken at the period value returns the count to 0 and raises an overflow event (flag bit 0).
- R2: In down mode (mode bits [1:0] = 1), each step subtracts one. A step taken at 0 loads the period value and raises an underflow event (flag bit 1).
- R3: In up/down mode (mode bits [1:0] = 2), the count rises to the period value and then falls, without wrapping. Reversing at the period value gives period-1 and raises overflow. Reversing at 0 gives 1 and raises underflow.
- R4: With one-shot set (mode bit 2), the timer stops running at the end of one period: on overflow in up mode, and on underflow in down and up/down modes.
- R5: The count changes only on a step (running and count_en high) or a reload. Otherwise it holds its value.
- R6: Stop clears running and takes priority over start and reload in the same cycle. Start sets running without altering the count.
- R7: Reload sets the count to 0 in up and up/down modes, or to the period value in down mode, and sets running.
- R8: A compare event (flag bit 3) occurs when a step produces a count equal to the active compare value. If swap is enabled (mode bit 3), the active and buffered compare values exchange on that event.
- R9: A capture strobe copies the current count into the capture register and the old capture value into the capture buffer, and raises a capture event (flag bit 2).
- R10: Event flags are sticky. Writing to address 4 clears each flag whose data bit is 1, and a new event in the same cycle keeps its flag set. `irq` is the OR of the flags.
- R11: `trig` is a one-cycle pulse of the event selected by mode bits [5:4] (0 overflow, 1 underflow, 2 capture, 3 compare). It appears in the same cycle the event's new count or value becomes visible.
- R12: Writes at address 0, 1, 2 and 3 load the period, active compare, buffered compare and mode word. After reset, all registers, the count, running, the flags and `trig` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 period, 1 compare, 2 compare buffer, 3 mode, 4 flag clear) |
| wr_data | input | CW | Register write data |
| start | input | 1 | Start strobe |
| stop | input | 1 | Stop strobe |
| reload | input | 1 | Reload strobe |
| capture | input | 1 | Capture strobe |
| count_en | input | 1 | Qualifies each count step |
| count | output | CW | Current count |
| running | output | 1 | Timer running |
| cmp_active | output | CW | Active compare value |
| cmp_buffer | output | CW | Buffered compare value |
| cap_value | output | CW | Latest captured count |
| cap_buffer | output | CW | Previous captured count |
| irq_flags | output | 4 | Sticky flags {compare, capture, underflow, overflow} |
| irq | output | 1 | OR of the flags |
| trig | output | 1 | Selected event pulse |

## Verification
The bench targets the turning points of the count.
- At the period value and at zero, a mis-ordered comparison would count one step too many or too few, and a missing wrap would run past the period.
- In up/down mode, a wrong turn would repeat the extreme value or wrap instead of reversing.
- When stop and start arrive together, start must not win. After a restart the count must resume from its held value, not restart from 0.
- Compare swapping must exchange the two values on every match; a design that only copied one way would lose the second threshold.
- The capture buffer must keep the older value rather than the new one.
- Clearing one flag must leave the others set.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    DIR_UP   = 2'd0,
    DIR_DOWN = 2'd1,
    DIR_UPDN = 2'd2
  } dir_e;

  typedef struct packed {
    logic [1:0] trig_sel;
    logic       swap_en;
    logic       oneshot;
    logic [1:0] dir;
  } mode_t;

  localparam int NUM_EVT  = 4;
  localparam int EVT_OVF  = 0;
  localparam int EVT_UNF  = 1;
  localparam int EVT_CAP  = 2;
  localparam int EVT_CMP  = 3;

  localparam logic [2:0] A_PERIOD = 3'd0;
  localparam logic [2:0] A_CMP    = 3'd1;
  localparam logic [2:0] A_CMPBUF = 3'd2;
  localparam logic [2:0] A_MODE   = 3'd3;
  localparam logic [2:0] A_CLR    = 3'd4;
endpackage

// File: rtl/evt_timer_count.sv
module evt_timer_count
  import evt_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period,
  input  logic [1:0]    dir,
  input  logic          oneshot,
  input  logic          start,
  input  logic          stop,
  input  logic          reload,
  input  logic          count_en,
  output logic [CW-1:0] cnt,
  output logic          running,
  output logic          step_vld,
  output logic [CW-1:0] cnt_nxt,
  output logic          ovf,
  output logic          unf
);
  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic falling;
  logic fall_nxt;
  logic wrap_o;
  logic wrap_u;
  logic end_one;

  always_comb begin
    cnt_nxt  = cnt;
    fall_nxt = falling;
    wrap_o   = 1'b0;
    wrap_u   = 1'b0;
    case (dir)
      DIR_DOWN: begin
        if (cnt == ZERO) begin
          cnt_nxt = period;
          wrap_u  = 1'b1;
        end else begin
          cnt_nxt = cnt - ONE;
        end
      end
      DIR_UPDN: begin
        if (!falling) begin
          if (cnt >= period) begin
            cnt_nxt  = (period == ZERO) ? ZERO : period - ONE;
            fall_nxt = 1'b1;
            wrap_o   = 1'b1;
          end else begin
            cnt_nxt = cnt + ONE;
          end
        end else begin
          if (cnt == ZERO) begin
            cnt_nxt  = (period == ZERO) ? ZERO : ONE;
            fall_nxt = 1'b0;
            wrap_u   = 1'b1;
          end else begin
            cnt_nxt = cnt - ONE;
          end
        end
      end
      default: begin
        if (cnt >= period) begin
          cnt_nxt = ZERO;
          wrap_o  = 1'b1;
        end else begin
          cnt_nxt = cnt + ONE;
        end
      end
    endcase
    end_one = (dir == DIR_UP || dir == 2'd3) ? wrap_o : wrap_u;
  end

  assign step_vld = running && count_en && !stop && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      falling <= 1'b0;
      ovf     <= 1'b0;
      unf     <= 1'b0;
    end else begin
      ovf <= step_vld && wrap_o;
      unf <= step_vld && wrap_u;
      if (stop) begin
        running <= 1'b0;
      end else if (reload) begin
        cnt     <= (dir == DIR_DOWN) ? period : ZERO;
        falling <= 1'b0;
        running <= 1'b1;
      end else begin
        if (start) running <= 1'b1;
        if (step_vld) begin
          cnt     <= cnt_nxt;
          falling <= fall_nxt;
          if (oneshot && end_one) running <= 1'b0;
        end
      end
    end
  end

  assert_count_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !reload) |=> $stable(cnt));

  assert_stop_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !running);

  assert_up_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && dir == DIR_UP) |-> (cnt == ZERO));

  assert_oneshot_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && oneshot && dir == DIR_UP) |-> !running);
endmodule

// File: rtl/evt_timer_compare.sv
module evt_timer_compare #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_act,
  input  logic          wr_buf,
  input  logic [CW-1:0] wdata,
  input  logic          swap_en,
  input  logic          step_vld,
  input  logic [CW-1:0] cnt_nxt,
  output logic [CW-1:0] cmp_act,
  output logic [CW-1:0] cmp_buf,
  output logic          cmp_evt
);
  logic hit;
  assign hit = step_vld && (cnt_nxt == cmp_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act <= '0;
      cmp_buf <= '0;
      cmp_evt <= 1'b0;
    end else begin
      cmp_evt <= hit;
      if (hit && swap_en) begin
        cmp_act <= cmp_buf;
        cmp_buf <= cmp_act;
      end
      if (wr_act) cmp_act <= wdata;
      if (wr_buf) cmp_buf <= wdata;
    end
  end

  assert_swap_exchange_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && swap_en && !wr_act && !wr_buf) |=>
      (cmp_act == $past(cmp_buf) && cmp_buf == $past(cmp_act)));
endmodule

// File: rtl/evt_timer_capture.sv
module evt_timer_capture #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_stb,
  input  logic [CW-1:0] cnt,
  output logic [CW-1:0] cap_val,
  output logic [CW-1:0] cap_bak,
  output logic          cap_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_val <= '0;
      cap_bak <= '0;
      cap_evt <= 1'b0;
    end else begin
      cap_evt <= cap_stb;
      if (cap_stb) begin
        cap_val <= cnt;
        cap_bak <= cap_val;
      end
    end
  end

  assert_capture_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> (cap_bak == $past(cap_val) && cap_val == $past(cnt)));
endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq
  import evt_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] events,
  input  logic               clr_wr,
  input  logic [NUM_EVT-1:0] clr_mask,
  input  logic [1:0]         trig_sel,
  output logic [NUM_EVT-1:0] flags,
  output logic               trig
);
  logic [NUM_EVT-1:0] clr_eff;
  assign clr_eff = clr_wr ? clr_mask : '0;
  assign trig    = events[trig_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_eff) | events;
  end

  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((flags & $past(flags)) == $past(flags)));

  assert_event_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|events) |=> ((flags & $past(events)) == $past(events)));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          start,
  input  logic          stop,
  input  logic          reload,
  input  logic          capture,
  input  logic          count_en,
  output logic [CW-1:0] count,
  output logic          running,
  output logic [CW-1:0] cmp_active,
  output logic [CW-1:0] cmp_buffer,
  output logic [CW-1:0] cap_value,
  output logic [CW-1:0] cap_buffer,
  output logic [3:0]    irq_flags,
  output logic          irq,
  output logic          trig
);
  localparam int MW = $bits(mode_t);

  logic [CW-1:0]      period_q;
  mode_t              mode_q;
  logic               step_vld;
  logic [CW-1:0]      cnt_nxt;
  logic               ovf;
  logic               unf;
  logic               cmp_evt;
  logic               cap_evt;
  logic [NUM_EVT-1:0] events;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      mode_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_PERIOD) period_q <= wr_data;
      if (wr_addr == A_MODE)   mode_q   <= mode_t'(wr_data[MW-1:0]);
    end
  end

  evt_timer_count #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .period(period_q), .dir(mode_q.dir),
    .oneshot(mode_q.oneshot), .start(start), .stop(stop), .reload(reload),
    .count_en(count_en), .cnt(count), .running(running), .step_vld(step_vld),
    .cnt_nxt(cnt_nxt), .ovf(ovf), .unf(unf)
  );

  evt_timer_compare #(.CW(CW)) u_compare (
    .clk(clk), .rst_n(rst_n),
    .wr_act(wr_en && wr_addr == A_CMP), .wr_buf(wr_en && wr_addr == A_CMPBUF),
    .wdata(wr_data), .swap_en(mode_q.swap_en), .step_vld(step_vld),
    .cnt_nxt(cnt_nxt), .cmp_act(cmp_active), .cmp_buf(cmp_buffer),
    .cmp_evt(cmp_evt)
  );

  evt_timer_capture #(.CW(CW)) u_capture (
    .clk(clk), .rst_n(rst_n), .cap_stb(capture), .cnt(count),
    .cap_val(cap_value), .cap_bak(cap_buffer), .cap_evt(cap_evt)
  );

  always_comb begin
    events          = '0;
    events[EVT_OVF] = ovf;
    events[EVT_UNF] = unf;
    events[EVT_CAP] = cap_evt;
    events[EVT_CMP] = cmp_evt;
  end

  evt_timer_irq u_irq (
    .clk(clk), .rst_n(rst_n), .events(events),
    .clr_wr(wr_en && wr_addr == A_CLR), .clr_mask(wr_data[NUM_EVT-1:0]),
    .trig_sel(mode_q.trig_sel), .flags(irq_flags), .trig(trig)
  );

  assign irq = |irq_flags;

  assert_irq_tracks_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flags == '0) |-> !irq);
endmodule

// File: tb/test_evt_timer.sv
module test_evt_timer;
  localparam int CW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          start = 1'b0, stop = 1'b0, reload = 1'b0, capture = 1'b0, count_en = 1'b0;
  logic [CW-1:0] count, cmp_active, cmp_buffer, cap_value, cap_buffer;
  logic          running, irq, trig;
  logic [3:0]    irq_flags;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer #(.CW(CW)) i_evt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .stop(stop), .reload(reload), .capture(capture), .count_en(count_en),
    .count(count), .running(running), .cmp_active(cmp_active), .cmp_buffer(cmp_buffer),
    .cap_value(cap_value), .cap_buffer(cap_buffer), .irq_flags(irq_flags), .irq(irq),
    .trig(trig)
  );

  // period, mode, compare, steps, expected count, expected flags, expected running
  localparam int VW = 69;
  localparam int NV = 9;
  localparam logic [VW-1:0] VEC [NV] = '{
    {16'd5, 8'h00, 16'd15, 8'd3,  16'd3, 4'b0000, 1'b1},  // R1 up, no wrap
    {16'd5, 8'h00, 16'd15, 8'd7,  16'd1, 4'b0001, 1'b1},  // R1 up, wrap
    {16'd5, 8'h01, 16'd15, 8'd3,  16'd2, 4'b0000, 1'b1},  // R2 down
    {16'd5, 8'h01, 16'd15, 8'd8,  16'd3, 4'b0010, 1'b1},  // R2 down, wrap
    {16'd4, 8'h02, 16'd15, 8'd6,  16'd2, 4'b0001, 1'b1},  // R3 top turn
    {16'd4, 8'h02, 16'd15, 8'd10, 16'd2, 4'b0011, 1'b1},  // R3 both turns
    {16'd3, 8'h04, 16'd15, 8'd8,  16'd0, 4'b0001, 1'b0},  // R4 up one-shot
    {16'd3, 8'h05, 16'd15, 8'd8,  16'd3, 4'b0010, 1'b0},  // R4 down one-shot
    {16'd7, 8'h00, 16'd4,  8'd5,  16'd5, 4'b1000, 1'b1}   // R8 compare
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    count_en = 1'b1;
    repeat (n) @(negedge clk);
    count_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 count", count, 0);
    chk("R12 running", running, 0);
    chk("R12 flags", irq_flags, 0);
    chk("R12 trig", trig, 0);
    chk("R12 cmp", cmp_active, 0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      wr(3'd0, v[68:53]);
      wr(3'd3, {8'h00, v[52:45]});
      wr(3'd1, v[44:29]);
      wr(3'd2, 16'd0);
      wr(3'd4, 16'hF);
      reload = 1'b1; @(negedge clk); reload = 1'b0;
      step(int'(v[28:21]));
      @(negedge clk);
      chk($sformatf("R1-table%0d count", i), count, v[20:5]);
      chk($sformatf("R10 table%0d flags", i), irq_flags, v[4:1]);
      chk($sformatf("R4 table%0d running", i), running, v[0]);
    end

    // R8 swap and R11 trigger on compare
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    wr(3'd0, 16'd9);
    wr(3'd3, 16'h0038);
    wr(3'd1, 16'd3);
    wr(3'd2, 16'd6);
    wr(3'd4, 16'hF);
    reload = 1'b1; @(negedge clk); reload = 1'b0;
    step(3);
    chk("R11 trig on compare", trig, 1);
    chk("R8 swapped active", cmp_active, 6);
    chk("R8 swapped buffer", cmp_buffer, 3);
    @(negedge clk);
    chk("R11 trig one cycle", trig, 0);
    step(3);
    chk("R8 second swap", cmp_active, 3);
    chk("R8 count at match", count, 6);

    // R9 capture double buffer
    capture = 1'b1; @(negedge clk); capture = 1'b0;
    chk("R9 capture value", cap_value, 6);
    chk("R9 capture buffer", cap_buffer, 0);
    step(2);
    capture = 1'b1; @(negedge clk); capture = 1'b0;
    chk("R9 capture value 2", cap_value, 8);
    chk("R9 capture buffer 2", cap_buffer, 6);
    @(negedge clk);
    chk("R10 flags set", irq_flags, 4'b1100);
    chk("R10 irq", irq, 1);
    wr(3'd4, 16'h0004);
    chk("R10 partial clear", irq_flags, 4'b1000);

    // R6 stop beats start, start keeps count; R5 hold
    stop = 1'b1; start = 1'b1; @(negedge clk); stop = 1'b0; start = 1'b0;
    chk("R6 stop wins", running, 0);
    step(2);
    chk("R5 no step when stopped", count, 8);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk("R6 start runs", running, 1);
    step(1);
    chk("R6 resume from held count", count, 9);
    repeat (3) @(negedge clk);
    chk("R5 hold without enable", count, 9);

    // R7 reload values
    reload = 1'b1; @(negedge clk); reload = 1'b0;
    chk("R7 reload up", count, 0);
    wr(3'd3, 16'h0001);
    reload = 1'b1; @(negedge clk); reload = 1'b0;
    chk("R7 reload down", count, 9);
    chk("R7 reload runs", running, 1);

    // R11 trigger on overflow, R12 period register
    wr(3'd3, 16'h0000);
    reload = 1'b1; @(negedge clk); reload = 1'b0;
    step(10);
    chk("R11 trig on overflow", trig, 1);
    chk("R12 period wrap", count, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule